// File: doc/BRIEF.md
# Current-Mode PWM Cycle Generator

This block produces the gate-enable pulse train for a fixed-frequency, current-mode flyback controller. It runs from a 16 MHz system clock. Its inputs are digital flags from external comparators: the primary current has reached its peak, the feedback level is below the burst-low threshold, and the feedback level is above the burst-high threshold. A 3-bit coarse feedback code and a single disable input from the fault logic complete the inputs. It drives one gate-enable output and a 3-bit soft-start step code for an external DAC that sets the peak-current threshold.

Each switching period is about 320 clocks (50 kHz). The length of each period is chosen pseudo-randomly within ±5 clocks. The pick comes from a free-running LFSR mixed with the feedback code, and it spreads the switching spectrum. A pulse starts at each period boundary. It ends at the first current trip that falls outside the leading-edge blanking window, or at the 67 % duty clamp. Soft-start raises the step code in eight equal steps. Burst mode skips whole periods, using two feedback thresholds with hysteresis. A new period length and a new burst decision take effect only at a period boundary, so a runt pulse cannot occur.

Top module: `pwm_cycle_gen`

## Requirements
- R1: Every switching period lasts between 315 and 325 clocks. The period length is fixed at the boundary where the period starts.
- R2: The period length is 315 + ((L ^ {5'b0, fb_code}) mod 11). L is an 8-bit Galois LFSR that advances every clock with feedback mask 0xB8. The resulting lengths vary from period to period.
- R3: With no current trip, the gate stays high for exactly floor(P*67/100) clocks of a period of P clocks, so the duty never exceeds 67 %.
- R4: The peak-current input is ignored during the first 4 clocks of each pulse, which are counter values 0 to 3. If the input is held high throughout, every pulse lasts exactly 5 clocks.
- R5: A current trip sampled in pulse clock d, where d is 4 or more and d is before the clamp, drives the gate low from clock d+1. The gate then stays low for the rest of the period.
- R6: After enable, ss_step starts at 0, rises by 1 every SS_STEP_CLKS clocks (the default is 40000, which is 2.5 ms), and holds at 7.
- R7: A high fb_low sample puts the block into skip state. In skip state no new pulse starts.
- R8: Only a high fb_high sample leaves skip state, and fb_high wins if both flags are high. While both flags are low, the state is kept in both directions.
- R9: While sw_disable is high, gate_en is low from the next clock onward, and ss_step is held at 0. Soft-start restarts from 0 when sw_disable goes low.
- R10: A pulse starts only when the period counter is at 0. Entering skip state during a pulse, or enabling in the middle of a period, never shortens a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 16 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_disable | input | 1 | Fault disable; holds the gate low and restarts soft-start |
| ipk_trip | input | 1 | Peak-current comparator flag |
| fb_low | input | 1 | Feedback below the burst-low threshold |
| fb_high | input | 1 | Feedback above the burst-high threshold |
| fb_code | input | 3 | Coarse feedback level, mixed into the dither |
| gate_en | output | 1 | Gate-enable to the power switch driver |
| ss_step | output | 3 | Soft-start step code for the current-limit DAC |

## Verification
The bench first runs the block freely, with a random feedback code and no trips. In this mode every measured period must fall within its window, every pulse width must equal the clamp for that period, and the run must show several distinct period lengths. A trip held high separates blanking from the clamp. Random trip offsets are placed on both sides of the 4-clock window, which tells an ignored trip apart from one that ends the pulse at d+1. Burst pulses are applied in the middle of a pulse and followed by long stretches with both flags low. This shows that skip state lets the current pulse finish, lasts without a new fb_low sample, and resumes only on fb_high. A disable applied in the middle of a pulse shows the cut in the next clock and the soft-start restart.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [0:0] {
    SW_RUN  = 1'b0,
    SW_SKIP = 1'b1
  } burst_st_e;

endpackage

// File: rtl/pwm_dither_src.sv
module pwm_dither_src #(
  parameter int          LFSR_W  = 8,
  parameter logic [7:0]  TAPS    = 8'hB8,
  parameter logic [7:0]  SEED    = 8'h5A,
  parameter int          FB_W    = 3,
  parameter int          NOM     = 320,
  parameter int          HALF    = 5,
  parameter int          PER_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FB_W-1:0]  fb_code,
  output logic [PER_W-1:0] per_pick
);

  localparam int SPAN    = 2 * HALF + 1;
  localparam int PER_MIN = NOM - HALF;

  logic [LFSR_W-1:0] lfsr_q, lfsr_n;
  logic [LFSR_W-1:0] mix;

  always_comb begin
    lfsr_n = {1'b0, lfsr_q[LFSR_W-1:1]};
    if (lfsr_q[0]) lfsr_n = lfsr_n ^ TAPS[LFSR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED[LFSR_W-1:0];
    else        lfsr_q <= lfsr_n;
  end

  assign mix      = lfsr_q ^ LFSR_W'(fb_code);
  assign per_pick = PER_W'(PER_MIN + (32'(mix) % SPAN));

endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart #(
  parameter int STEPS     = 8,
  parameter int STEP_CLKS = 40000,
  parameter int LVL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  output logic [LVL_W-1:0] level
);

  localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STEP_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;

  always_comb begin
    cnt_n = cnt_q;
    lvl_n = lvl_q;
    if (hold) begin
      cnt_n = '0;
      lvl_n = '0;
    end else if (lvl_q != LVL_TOP) begin
      if (cnt_q == CNT_END) begin
        cnt_n = '0;
        lvl_n = lvl_q + LVL_W'(1);
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      lvl_q <= lvl_n;
    end
  end

  assign level = lvl_q;

endmodule

// File: rtl/pwm_burst_ctl.sv
module pwm_burst_ctl
  import pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic below,
  input  logic above,
  output logic skip
);

  burst_st_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (above)      st_n = SW_RUN;
    else if (below) st_n = SW_SKIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SW_RUN;
    else        st_q <= st_n;
  end

  assign skip = (st_q == SW_SKIP);

endmodule

// File: rtl/pwm_cycle_gen.sv
module pwm_cycle_gen #(
  parameter int NOM_PERIOD  = 320,
  parameter int DITHER_HALF = 5,
  parameter int BLANK_CLKS  = 4,
  parameter int DUTY_PCT    = 67,
  parameter int SS_STEPS    = 8,
  parameter int SS_STEP_CLKS = 40000,
  parameter int FB_W        = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sw_disable,
  input  logic                         ipk_trip,
  input  logic                         fb_low,
  input  logic                         fb_high,
  input  logic [FB_W-1:0]              fb_code,
  output logic                         gate_en,
  output logic [$clog2(SS_STEPS)-1:0]  ss_step
);

  localparam int PER_W   = $clog2(NOM_PERIOD + DITHER_HALF + 1);
  localparam int LVL_W   = $clog2(SS_STEPS);
  localparam int CLAMP0  = (NOM_PERIOD * DUTY_PCT) / 100;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [PER_W-1:0] per_pick;
  logic [PER_W-1:0] clamp_pick;
  logic             skip;

  pwm_dither_src #(
    .LFSR_W (8),
    .TAPS   (8'hB8),
    .SEED   (8'h5A),
    .FB_W   (FB_W),
    .NOM    (NOM_PERIOD),
    .HALF   (DITHER_HALF),
    .PER_W  (PER_W)
  ) u_dither (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .fb_code  (fb_code),
    .per_pick (per_pick)
  );

  pwm_softstart #(
    .STEPS     (SS_STEPS),
    .STEP_CLKS (SS_STEP_CLKS),
    .LVL_W     (LVL_W)
  ) u_ss (
    .clk   (clk),
    .rst_n (rst_core_n),
    .hold  (sw_disable),
    .level (ss_step)
  );

  pwm_burst_ctl u_burst (
    .clk   (clk),
    .rst_n (rst_core_n),
    .below (fb_low),
    .above (fb_high),
    .skip  (skip)
  );

  assign clamp_pick = PER_W'((32'(per_pick) * DUTY_PCT) / 100);

  logic [PER_W-1:0] cnt_q, cnt_n;
  logic [PER_W-1:0] period_q, period_n;
  logic [PER_W-1:0] clamp_q, clamp_n;
  logic             gate_q, gate_n;
  logic             at_end;
  logic             trip_live;
  logic             cnt_en;

  assign cnt_en = 1'b1;
  assign at_end = (cnt_q == period_q - PER_W'(1));

  generate
    if (BLANK_CLKS == 0) begin : g_noblank
      assign trip_live = ipk_trip;
    end else begin : g_blank
      assign trip_live = ipk_trip && (cnt_q >= PER_W'(BLANK_CLKS));
    end
  endgenerate

  always_comb begin
    cnt_n    = cnt_q + PER_W'(1);
    period_n = period_q;
    clamp_n  = clamp_q;
    gate_n   = gate_q;
    if (at_end) begin
      cnt_n    = '0;
      period_n = per_pick;
      clamp_n  = clamp_pick;
      gate_n   = !sw_disable && !skip;
    end else if (gate_q) begin
      if (cnt_q + PER_W'(1) == clamp_q) gate_n = 1'b0;
      if (trip_live)                    gate_n = 1'b0;
    end
    if (sw_disable) gate_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cnt_q    <= '0;
      period_q <= PER_W'(NOM_PERIOD);
      clamp_q  <= PER_W'(CLAMP0);
      gate_q   <= 1'b0;
    end else if (cnt_en) begin
      cnt_q    <= cnt_n;
      period_q <= period_n;
      clamp_q  <= clamp_n;
      gate_q   <= gate_n;
    end
  end

  assign gate_en = gate_q;

endmodule

// File: rtl/pwm_cycle_chk.sv
module pwm_cycle_chk #(
  parameter int PER_W       = 9,
  parameter int LVL_W       = 3,
  parameter int NOM_PERIOD  = 320,
  parameter int DITHER_HALF = 5,
  parameter int BLANK_CLKS  = 4,
  parameter int DUTY_PCT    = 67
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_disable,
  input logic             gate_en,
  input logic             skip,
  input logic [PER_W-1:0] cnt_q,
  input logic [PER_W-1:0] period_q,
  input logic [PER_W-1:0] clamp_q,
  input logic [LVL_W-1:0] ss_step
);

  // R1: the period register always holds a length inside the dither window
  p_period_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q >= PER_W'(NOM_PERIOD - DITHER_HALF)) &&
    (period_q <= PER_W'(NOM_PERIOD + DITHER_HALF)));

  // R3: the clamp never exceeds the duty limit, and the gate respects it
  p_clamp_ratio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(clamp_q) * 100) <= (32'(period_q) * DUTY_PCT));

  p_gate_in_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> (cnt_q < clamp_q));

  // R4: a pulse ends no earlier than one clock after the blanking window
  p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_en) && !$past(sw_disable)) |-> (cnt_q > PER_W'(BLANK_CLKS)));

  // R9: disable forces the gate low on the next clock
  p_disable_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_disable |=> !gate_en);

  // R9: soft-start is held at its first step while disabled
  p_ss_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_disable) |-> (ss_step == '0));

  // R6: the step code only rises while enabled
  p_ss_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_disable && !$past(sw_disable)) |-> (ss_step >= $past(ss_step)));

  // R10, R7: pulses start only at counter 0 and never while skipping
  p_start_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> ((cnt_q == '0) && !$past(skip)));

endmodule

bind pwm_cycle_gen pwm_cycle_chk #(
  .PER_W       (PER_W),
  .LVL_W       (LVL_W),
  .NOM_PERIOD  (NOM_PERIOD),
  .DITHER_HALF (DITHER_HALF),
  .BLANK_CLKS  (BLANK_CLKS),
  .DUTY_PCT    (DUTY_PCT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_disable (sw_disable),
  .gate_en    (gate_en),
  .skip       (skip),
  .cnt_q      (cnt_q),
  .period_q   (period_q),
  .clamp_q    (clamp_q),
  .ss_step    (ss_step)
);

// File: tb/sim_pwm_cycle_gen.sv
`timescale 1ns/1ps
module sim_pwm_cycle_gen;

  localparam int STEP = 500;
  localparam int PMIN = 315;
  localparam int PMAX = 325;
  localparam int BLNK = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dis, trip, blo, bhi;
  logic [2:0] fbc;
  logic       gate;
  logic [2:0] ssl;

  always #4 clk = ~clk;

  pwm_cycle_gen #(.SS_STEP_CLKS(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_disable(dis), .ipk_trip(trip),
    .fb_low(blo), .fb_high(bhi), .fb_code(fbc),
    .gate_en(gate), .ss_step(ssl)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  function automatic int exp_clamp(int p);
    return (p * 67) / 100;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  int  cyc = 0, rise_cyc = 0, last_w = 0, rises = 0, falls = 0;
  bit  gate_prev = 0, have_rise = 0, mon_on = 0, chk_w = 0, rand_fb = 0;
  bit [10:0] seen = '0;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (rand_fb) fbc = 3'($urandom_range(0, 7));
    if (!mon_on) have_rise = 0;
    if (gate && !gate_prev) begin
      if (mon_on && have_rise) begin
        int p;
        p = cyc - rise_cyc;
        chk(p >= PMIN && p <= PMAX, "R1 period", p, 320);
        if (p >= PMIN && p <= PMAX) seen[p-PMIN] = 1'b1;
        if (chk_w) chk(last_w == exp_clamp(p), "R3 on-time", last_w, exp_clamp(p));
      end
      have_rise = 1;
      rise_cyc  = cyc;
      rises++;
    end
    if (!gate && gate_prev) begin
      last_w = cyc - rise_cyc;
      falls++;
    end
    gate_prev = gate;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    report();
  end

  task automatic trip_at(int d);
    int n, nf;
    n = rises;
    wait (rises != n);
    nf = falls;
    @(negedge clk);
    repeat (d) @(negedge clk);
    trip = 1;
    @(negedge clk);
    trip = 0;
    wait (falls != nf);
    if (d >= BLNK)
      chk(last_w == d + 1, "R5 trip ends pulse", last_w, d + 1);
    else
      chk(last_w >= exp_clamp(PMIN) && last_w <= exp_clamp(PMAX),
          "R4 blanked trip ignored", last_w, exp_clamp(320));
  endtask

  task automatic count_rises(int ncyc, output int cnt);
    int n;
    n = rises;
    repeat (ncyc) @(negedge clk);
    cnt = rises - n;
  endtask

  initial begin
    int nr;
    void'($urandom(32'd20240611));
    rst_n = 0; dis = 1; trip = 0; blo = 0; bhi = 0; fbc = 3'd0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk(gate == 1'b0, "R9 reset gate low", gate, 0);
    chk(ssl == 3'd0, "R6 reset step", ssl, 0);

    // enable: soft-start ramp with free switching (R6, R1, R2, R3, R10)
    dis = 0; rand_fb = 1; mon_on = 1; chk_w = 1;
    for (int k = 0; k <= 9; k++) begin
      repeat ((k == 0) ? STEP / 2 : STEP) @(negedge clk);
      chk(ssl == 3'((k > 7) ? 7 : k), "R6 step level", ssl, (k > 7) ? 7 : k);
    end
    wait (rises >= 40);
    @(negedge clk);
    chk($countones(seen) >= 4, "R2 dithered periods", $countones(seen), 4);

    // blanking with a trip held high (R4)
    mon_on = 0; chk_w = 0;
    trip = 1;
    begin
      int n;
      n = falls;
      wait (falls >= n + 2);
    end
    for (int i = 0; i < 3; i++) begin
      int n;
      n = falls;
      wait (falls != n);
      chk(last_w == BLNK + 1, "R4 held trip width", last_w, BLNK + 1);
    end
    @(negedge clk);
    trip = 0;

    // directed and random trip offsets (R4, R5)
    trip_at(0);
    trip_at(BLNK - 1);
    trip_at(BLNK);
    for (int i = 0; i < 14; i++) trip_at($urandom_range(0, 60));

    // burst entry during a pulse: pulse completes (R10), then skip (R7)
    begin
      int n, nf;
      n = rises;
      wait (rises != n);
      nf = falls;
      @(negedge clk);
      repeat (50) @(negedge clk);
      blo = 1;
      @(negedge clk);
      blo = 0;
      wait (falls != nf);
      chk(last_w >= exp_clamp(PMIN) && last_w <= exp_clamp(PMAX),
          "R10 pulse not cut by burst", last_w, exp_clamp(320));
    end
    count_rises(1300, nr);
    chk(nr == 0, "R7 no pulses in skip", nr, 0);
    chk(nr == 0, "R8 skip held with both flags low", nr, 0);

    // both flags high: high wins (R8)
    blo = 1; bhi = 1;
    @(negedge clk);
    blo = 0; bhi = 0;
    count_rises(340, nr);
    chk(nr == 1, "R8 resume on high", nr, 1);
    count_rises(1300, nr);
    chk(nr >= 4, "R8 run held with both flags low", nr, 4);

    // disable in the middle of a pulse (R9)
    begin
      int n;
      n = rises;
      wait (rises != n);
      @(negedge clk);
      repeat (20) @(negedge clk);
      dis = 1;
      @(negedge clk);
      chk(gate == 1'b0, "R9 gate cut next clock", gate, 0);
      chk(ssl == 3'd0, "R9 step reset", ssl, 0);
    end
    count_rises(700, nr);
    chk(nr == 0, "R9 no pulses while disabled", nr, 0);

    // re-enable mid-period: first pulse has full clamp width (R10)
    repeat (37) @(negedge clk);
    dis = 0;
    begin
      int nf;
      nf = falls;
      wait (falls != nf);
      chk(last_w >= exp_clamp(PMIN) && last_w <= exp_clamp(PMAX),
          "R10 first pulse full width", last_w, exp_clamp(320));
    end
    chk(ssl <= 3'd1, "R6 soft-start restarted", ssl, 0);

    repeat (5) @(negedge clk);
    report();
  end

endmodule